// File: doc/BRIEF.md
# Reset-Cause and Supply-Monitor Status Register

This block is an 8-bit status and control register on a simple CPU register bus. It tells software what caused the most recent reset, shows whether the clock multiplier has locked, and shows whether the supply is under the detector threshold. It also holds the enable for a supply-low interrupt.

The reset sources reach it as one-cycle event pulses. These are a watchdog reset event and a low-voltage reset event; an external-pin reset is just the general reset with no event pulse. The PLL lock and the supply comparator arrive as asynchronous levels and pass through synchronisers.

The cause flags live outside the general reset domain, so their values survive the reset they describe. Each flag has its own clearing rule. The interrupt request rises on a new supply-low condition. The CPU's interrupt-acknowledge strobe removes it.

Top module: `rcs_status_reg`

## Requirements
- R1: Bits 7, 6 and 5 always read 0, and writing ones to them changes nothing.
- R2: A watchdog reset event sets bit 4 (watchdog cause). A write with bit 4 at 0 clears it. A write with bit 4 at 1 or any read leaves it unchanged.
- R3: A low-voltage reset event sets bit 2 (low-voltage cause) and forces bit 4 to 0. This holds even when a watchdog event arrives in the same cycle.
- R4: A read returns bit 2 as it stands and clears it on that clock edge. A watchdog event or an external reset (general reset with no event) leaves bit 2 set.
- R5: When a read and a low-voltage event fall in the same cycle, bit 2 is set afterwards.
- R6: Bit 3 shows the PLL lock level two clocks after it changes, and writes do not affect it.
- R7: Bit 1 shows the supply comparator level (1 = supply below threshold) two clocks after it changes, and writes do not affect it.
- R8: Bit 0 is the interrupt enable. It is written and read back by software and returns to 0 on the general reset.
- R9: The interrupt request rises only when bit 1 goes from 0 to 1 while bit 0 is 1. A level that is already high when the enable is set raises nothing.
- R10: A pending request drops on the clock after the acknowledge strobe, or once bit 0 is 0.
- R11: The general reset clears the enable and the pending request, and it leaves bits 4 and 2 as recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | General register reset, active low, asynchronous |
| bus_we | input | 1 | Write strobe for the register |
| bus_re | input | 1 | Read strobe for the register (clears bit 2) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| evt_wdog_rst | input | 1 | One-cycle pulse: a watchdog reset happened |
| evt_lv_rst | input | 1 | One-cycle pulse: a low-voltage reset happened |
| pll_lock_lvl | input | 1 | Asynchronous PLL lock level |
| sup_low_lvl | input | 1 | Asynchronous supply comparator level, 1 = below threshold |
| irq_ack | input | 1 | Interrupt-acknowledge strobe from the CPU |
| irq_req | output | 1 | Supply-low interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a stacked reset history: a low-voltage reset, then a watchdog reset, then a plain external reset, with no read in between. The bench gets there by running three reset sequences back to back and only then reading. That read must show both cause bits, and the next read must show only the watchdog bit. The second is a read that coincides with a low-voltage event. The bench lifts the read strobe and the event pulse on the same clock while the general reset is released, then reads again to confirm the flag is set. For the interrupt, the bench moves the comparator level with the enable both clear and set. This separates a true rising edge from a level that was already high.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
   localparam int REG_W   = 8;
   localparam int BIT_WDG = 4;
   localparam int BIT_PLL = 3;
   localparam int BIT_LVR = 2;
   localparam int BIT_SUP = 1;
   localparam int BIT_IE  = 0;

   typedef struct packed {
      logic wdg;
      logic pll;
      logic lvr;
      logic sup;
      logic ie;
   } rcs_fields_t;
endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rcs_cause_flags.sv
module rcs_cause_flags (
   input  logic clk,
   input  logic evt_wdog,
   input  logic evt_lv,
   input  logic wr_en,
   input  logic wr_wdg_bit,
   input  logic rd_en,
   output logic wdg_flag,
   output logic lvr_flag
);
   // No reset: these flags must outlive the reset they report.
   logic wdg_q, lvr_q;

   always_ff @(posedge clk) begin
      if (evt_lv)                       wdg_q <= 1'b0;
      else if (evt_wdog)                wdg_q <= 1'b1;
      else if (wr_en && !wr_wdg_bit)    wdg_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (evt_lv)     lvr_q <= 1'b1;
      else if (rd_en) lvr_q <= 1'b0;
   end

   assign wdg_flag = wdg_q;
   assign lvr_flag = lvr_q;
endmodule

// File: rtl/rcs_sup_irq.sv
module rcs_sup_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_sync,
   input  logic wr_en,
   input  logic wr_ie_bit,
   input  logic ack,
   output logic ie,
   output logic irq
);
   logic ie_q, prev_q, pend_q, rise;

   assign rise = sup_sync && !prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= sup_sync;
         if (wr_en) ie_q <= wr_ie_bit;
         if (!ie_q)     pend_q <= 1'b0;
         else if (rise) pend_q <= 1'b1;
         else if (ack)  pend_q <= 1'b0;
      end
   end

   assign ie  = ie_q;
   assign irq = pend_q;
endmodule

// File: rtl/rcs_status_reg.sv
module rcs_status_reg #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit PLL_SYNC    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              evt_wdog_rst,
   input  logic              evt_lv_rst,
   input  logic              pll_lock_lvl,
   input  logic              sup_low_lvl,
   input  logic              irq_ack,
   output logic              irq_req
);
   import rcs_pkg::*;

   localparam int RSVD_LO = BIT_WDG + 1;

   if (DATA_W != REG_W) begin : g_bad_width
      $error("rcs_status_reg: DATA_W must equal %0d", REG_W);
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rcs_status_reg: SYNC_STAGES must be at least 2");
   end

   rcs_fields_t f;
   logic        sup_s, pll_s;
   logic        unused_wdata;

   assign unused_wdata = ^{bus_wdata[DATA_W-1:RSVD_LO], bus_wdata[BIT_PLL:BIT_SUP]};

   rcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sup_sync (
      .clk(clk), .rst_n(rst_n), .d_async(sup_low_lvl), .q_sync(sup_s));

   if (PLL_SYNC) begin : g_pll_sync
      rcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pll_sync (
         .clk(clk), .rst_n(rst_n), .d_async(pll_lock_lvl), .q_sync(pll_s));
   end else begin : g_pll_direct
      assign pll_s = pll_lock_lvl;
   end

   rcs_cause_flags u_flags (
      .clk(clk), .evt_wdog(evt_wdog_rst), .evt_lv(evt_lv_rst),
      .wr_en(bus_we), .wr_wdg_bit(bus_wdata[BIT_WDG]), .rd_en(bus_re),
      .wdg_flag(f.wdg), .lvr_flag(f.lvr));

   rcs_sup_irq u_irq (
      .clk(clk), .rst_n(rst_n), .sup_sync(sup_s),
      .wr_en(bus_we), .wr_ie_bit(bus_wdata[BIT_IE]), .ack(irq_ack),
      .ie(f.ie), .irq(irq_req));

   assign f.pll = pll_s;
   assign f.sup = sup_s;

   always_comb begin
      bus_rdata          = '0;
      bus_rdata[BIT_WDG] = f.wdg;
      bus_rdata[BIT_PLL] = f.pll;
      bus_rdata[BIT_LVR] = f.lvr;
      bus_rdata[BIT_SUP] = f.sup;
      bus_rdata[BIT_IE]  = f.ie;
   end
endmodule

// File: rtl/rcs_status_reg_chk.sv
module rcs_status_reg_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic              bus_re,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              evt_wdog_rst,
   input logic              evt_lv_rst,
   input logic              irq_ack,
   input logic              irq_req
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[7:5] == 3'b000); // R1
   AST_WDG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_wdog_rst && !evt_lv_rst) |=> bus_rdata[4]); // R2
   AST_WDG_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_wdata[4] && !evt_wdog_rst && !evt_lv_rst) |=> !bus_rdata[4]); // R2
   AST_LV_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_lv_rst |=> (bus_rdata[2] && !bus_rdata[4])); // R3
   AST_LV_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !evt_lv_rst) |=> !bus_rdata[2]); // R4
   AST_LV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[2] && !bus_re) |=> bus_rdata[2]); // R4
   AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> ($past(bus_rdata[1]) && $past(bus_rdata[0]))); // R9
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rdata[0] |=> !irq_req); // R10
   AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !(bus_rdata[1] && !$past(bus_rdata[1]))) |=> !irq_req); // R10
endmodule

bind rcs_status_reg rcs_status_reg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rcs_status_reg_tb.sv
`timescale 1ns/1ps
module rcs_status_reg_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0, bus_re = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       evt_wdog_rst = 1'b0, evt_lv_rst = 1'b0;
   logic       pll_lock_lvl = 1'b0, sup_low_lvl = 1'b0;
   logic       irq_ack = 1'b0;
   logic       irq_req;

   int errors = 0;
   int checks = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   rcs_status_reg u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_wdog_rst(evt_wdog_rst), .evt_lv_rst(evt_lv_rst),
      .pll_lock_lvl(pll_lock_lvl), .sup_low_lvl(sup_low_lvl),
      .irq_ack(irq_ack), .irq_req(irq_req));

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // Monitor: pops expected read data while a read strobe is up.
   initial forever begin
      @(negedge clk);
      #1;
      if (bus_re && exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
   end

   task automatic rd(input logic [7:0] exp, input string tag, input logic with_lv = 1'b0);
      @(negedge clk);
      bus_re = 1'b1;
      evt_lv_rst = with_lv;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_re = 1'b0;
      evt_lv_rst = 1'b0;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1;
      bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rst_seq(input logic wd, input logic lv);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      evt_wdog_rst = wd;
      evt_lv_rst = lv;
      @(negedge clk);
      evt_wdog_rst = 1'b0;
      evt_lv_rst = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // Power-up: low-voltage reset gives a known flag state
      rst_seq(1'b0, 1'b1);
      check("R11 irq low after reset", {7'b0, irq_req}, 8'h00);
      rd(8'h04, "R3 lv cause after reset, ie cleared R8");
      rd(8'h00, "R4 lv flag cleared by read");
      // Read-only and reserved bits ignore writes
      wr(8'hFF);
      rd(8'h01, "R1 R6 R7 R2 only enable takes write of FF");
      wr(8'h00);
      rd(8'h00, "R8 enable written back to 0");
      // Watchdog cause
      rst_seq(1'b1, 1'b0);
      rd(8'h10, "R2 watchdog cause");
      rd(8'h10, "R2 read leaves watchdog flag");
      wr(8'hEF);
      rd(8'h01, "R2 write zero clears watchdog flag");
      wr(8'h00);
      // Stacked history: lv, watchdog, external
      rst_seq(1'b0, 1'b1);
      rst_seq(1'b1, 1'b0);
      rst_seq(1'b0, 1'b0);
      rd(8'h14, "R4 lv flag survives watchdog and external reset");
      rd(8'h10, "R4 lv flag cleared by read, watchdog kept R11");
      rst_seq(1'b0, 1'b1);
      rd(8'h04, "R3 lv reset clears watchdog flag");
      rd(8'h00, "R4 second read");
      // Both events together
      rst_seq(1'b1, 1'b1);
      rd(8'h04, "R3 lv wins over simultaneous watchdog");
      rd(8'h00, "R4 clear after simultaneous");
      // Read colliding with lv event
      rd(8'h00, "R5 read in collision cycle", 1'b1);
      rd(8'h04, "R5 set wins over read clear");
      rd(8'h00, "R5 cleared by later read");
      // PLL lock
      pll_lock_lvl = 1'b1;
      wait_cyc(4);
      rd(8'h08, "R6 pll lock shown");
      pll_lock_lvl = 1'b0;
      wait_cyc(4);
      rd(8'h00, "R6 pll unlock shown");
      // Supply detector and interrupt
      wr(8'h01);
      sup_low_lvl = 1'b1;
      wait_cyc(5);
      check("R9 irq on rising supply-low", {7'b0, irq_req}, 8'h01);
      rd(8'h03, "R7 supply-low flag shown");
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      check("R10 ack clears irq", {7'b0, irq_req}, 8'h00);
      wait_cyc(4);
      check("R9 steady level gives no new irq", {7'b0, irq_req}, 8'h00);
      sup_low_lvl = 1'b0;
      wait_cyc(4);
      rd(8'h01, "R7 supply-low flag cleared");
      wr(8'h00);
      sup_low_lvl = 1'b1;
      wait_cyc(5);
      check("R9 no irq with enable clear", {7'b0, irq_req}, 8'h00);
      wr(8'h01);
      wait_cyc(4);
      check("R9 enabling on high level gives no irq", {7'b0, irq_req}, 8'h00);
      sup_low_lvl = 1'b0;
      wait_cyc(4);
      sup_low_lvl = 1'b1;
      wait_cyc(5);
      check("R9 irq on second rising edge", {7'b0, irq_req}, 8'h01);
      wr(8'h00);
      wait_cyc(2);
      check("R10 enable clear drops irq", {7'b0, irq_req}, 8'h00);
      sup_low_lvl = 1'b0;
      wait_cyc(4);
      wr(8'h01);
      sup_low_lvl = 1'b1;
      wait_cyc(5);
      check("R9 irq pending before reset", {7'b0, irq_req}, 8'h01);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R11 reset drops irq", {7'b0, irq_req}, 8'h00);
      rst_n = 1'b1;
      sup_low_lvl = 1'b0;
      wait_cyc(4);
      rd(8'h00, "R11 enable cleared by reset");
      wait_cyc(3);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule